// File: doc/BRIEF.md
# Programmable-Tick Cascaded Watch Counter

This block keeps wall-clock style time as five fields: seconds, minutes, hours, days and years. A divider counts system clock cycles and emits a one-cycle tick once per programmed period. That tick advances a chain of rollover counters, and each counter passes a registered carry pulse to the next one.

A run input acts as a clock enable for the whole block. While it is low, everything freezes: the divider, the counters, the carries in flight and the alignment registers. Because every carry is registered, each stage updates one cycle after the stage before it. A short delay line on each field makes up the difference, so all fields that one tick touches change on the same clock edge. At a 100 MHz system clock, a divide value of 100,000,000 gives real time. Smaller values make the watch run faster in proportion.

Top module: `watch_core`

## Requirements
- R1: A synchronous active-high reset sets every output field to zero and clears the divider count and every pipeline register.
- R2: With run high, a tick is issued every D enabled cycles, where D is the divide input. D is sampled in the first enabled cycle after each divider wrap, so a change in the middle of a period takes effect only from the following period.
- R3: A divide value of 0 or 1 acts as 1: a tick is issued on every enabled cycle.
- R4: While run is low, no output field changes and the divider does not count. When run returns high, counting resumes from exactly the frozen state.
- R5: Seconds count 0 to 59. The tick after 59 gives 0 and carries into minutes.
- R6: Minutes count 0 to 59 and carry into hours. Hours count 0 to 23 and carry into days.
- R7: Days count 0 to 364. The carry after 364 gives 0 and advances years.
- R8: Years form a 16-bit counter that stops at its maximum value and stays there.
- R9: Every field changed by one tick changes on the same edge. With run held high from reset release and divide value P ≥ 1, seconds first read 1 right after the (P+5)-th rising edge. Whenever hours change, seconds and minutes read 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Clock enable for the whole watch |
| div_i | input | 32 | Tick period in clock cycles (0 and 1 both mean 1) |
| sec_o | output | 6 | Seconds field |
| min_o | output | 6 | Minutes field |
| hour_o | output | 5 | Hours field |
| day_o | output | 9 | Day-of-year field |
| year_o | output | 16 | Years field, saturating |

## Verification
The divider is driven with a small period, with a period changed in the middle of a count, and with the values 0, 1 and 2. Comparing these shows that sampling happens only at the wrap and that the degenerate values are clamped. Run is toggled in short bursts while ticks and carries are in flight, which separates a true freeze from a design that drops or repeats a pulse. A long stretch at one tick per cycle carries a full hour and a full day, so the fields must line up across every rollover. A second instance with two-state fields and a 2-bit year reaches day wrap and year saturation within the run.

// File: rtl/watch_pkg.sv
package watch_pkg;

    localparam int DIV_W        = 32;
    localparam int SEC_MOD_DEF  = 60;
    localparam int MIN_MOD_DEF  = 60;
    localparam int HOUR_MOD_DEF = 24;
    localparam int DAY_MOD_DEF  = 365;
    localparam int YEAR_W_DEF   = 16;
    localparam int NUM_FIELDS   = 5;

    typedef enum int {
        F_SEC  = 0,
        F_MIN  = 1,
        F_HOUR = 2,
        F_DAY  = 3,
        F_YEAR = 4
    } field_e;

    // extra register stages a field needs to line up with the last stage
    function automatic int align_depth(input field_e f);
        return NUM_FIELDS - 1 - int'(f);
    endfunction

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] last;
        logic             tick;
    } div_state_t;

    // last count value of a period; 0 and 1 both collapse to a single cycle
    function automatic logic [DIV_W-1:0] eff_last(input logic [DIV_W-1:0] d);
        return (d <= DIV_W'(1)) ? '0 : d - DIV_W'(1);
    endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider
    import watch_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    div_state_t       st_q, st_d;
    logic [DIV_W-1:0] cur_last;
    logic             wrap;

    always_comb begin
        cur_last = (st_q.cnt == '0) ? eff_last(div_i) : st_q.last;
        wrap     = (st_q.cnt == cur_last);
        st_d     = st_q;
        if (en_i) begin
            st_d.tick = wrap;
            st_d.cnt  = wrap ? '0 : st_q.cnt + DIV_W'(1);
            if (st_q.cnt == '0) begin
                st_d.last = cur_last;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

    // R2: a running count never passes the period captured at its start
    a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.cnt != '0) |-> (st_q.cnt <= st_q.last));

    // R3: a clamped period ticks from the very next enabled edge
    a_r3_unit_period: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && div_i <= DIV_W'(1) && st_q.cnt == '0) |=> st_q.tick);

    // R4: divider state frozen while disabled
    a_r4_div_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i) |=> $stable(st_q));

endmodule

// File: rtl/rollover_stage.sv
module rollover_stage #(
    parameter int MOD = 60,
    parameter int W   = $clog2(MOD)
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    input  logic         adv_i,
    output logic [W-1:0] val_o,
    output logic         carry_o
);

    localparam logic [W-1:0] LAST = W'(MOD - 1);

    logic [W-1:0] val_q;
    logic         carry_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            val_q   <= '0;
            carry_q <= 1'b0;
        end else if (en_i) begin
            carry_q <= 1'b0;
            if (adv_i) begin
                if (val_q == LAST) begin
                    val_q   <= '0;
                    carry_q <= 1'b1;
                end else begin
                    val_q <= val_q + W'(1);
                end
            end
        end
    end

    assign val_o   = val_q;
    assign carry_o = carry_q;

    // R5: the field never leaves its modulus range
    a_r5_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        val_q <= LAST);

    // R5: a carry is raised only together with a wrapped field
    a_r5_carry_at_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        carry_q |-> (val_q == '0));

    // R4: counter and carry frozen while disabled
    a_r4_stage_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i) |=> ($stable(val_q) && $stable(carry_q)));

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    input  logic         adv_i,
    output logic [W-1:0] val_o
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] val_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            val_q <= '0;
        end else if (en_i && adv_i && val_q != MAXV) begin
            val_q <= val_q + W'(1);
        end
    end

    assign val_o = val_q;

    // R8: once at the top value the counter stays there
    a_r8_hold_max: assert property (@(posedge clk_i) disable iff (rst_i)
        (val_q == MAXV) |=> (val_q == MAXV));

endmodule

// File: rtl/align_pipe.sv
module align_pipe #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign q_o = d_i;
        end else begin : g_regs
            logic [W-1:0] sr_q [DEPTH];
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
                end else if (en_i) begin
                    sr_q[0] <= d_i;
                    for (int i = 1; i < DEPTH; i++) sr_q[i] <= sr_q[i-1];
                end
            end
            assign q_o = sr_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/watch_core.sv
module watch_core
    import watch_pkg::*;
#(
    parameter  int SEC_MOD  = SEC_MOD_DEF,
    parameter  int MIN_MOD  = MIN_MOD_DEF,
    parameter  int HOUR_MOD = HOUR_MOD_DEF,
    parameter  int DAY_MOD  = DAY_MOD_DEF,
    parameter  int YEAR_W   = YEAR_W_DEF,
    localparam int SEC_W    = $clog2(SEC_MOD),
    localparam int MIN_W    = $clog2(MIN_MOD),
    localparam int HOUR_W   = $clog2(HOUR_MOD),
    localparam int DAY_W    = $clog2(DAY_MOD)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              run_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic [SEC_W-1:0]  sec_o,
    output logic [MIN_W-1:0]  min_o,
    output logic [HOUR_W-1:0] hour_o,
    output logic [DAY_W-1:0]  day_o,
    output logic [YEAR_W-1:0] year_o
);

    logic              tick;
    logic              c_sec, c_min, c_hour, c_day;
    logic [SEC_W-1:0]  sec_raw;
    logic [MIN_W-1:0]  min_raw;
    logic [HOUR_W-1:0] hour_raw;
    logic [DAY_W-1:0]  day_raw;
    logic [YEAR_W-1:0] year_raw;

    tick_divider u_div (
        .clk_i (clk_i), .rst_i (rst_i), .en_i (run_i),
        .div_i (div_i), .tick_o (tick)
    );

    rollover_stage #(.MOD(SEC_MOD), .W(SEC_W)) u_sec (
        .clk_i (clk_i), .rst_i (rst_i), .en_i (run_i), .adv_i (tick),
        .val_o (sec_raw), .carry_o (c_sec)
    );

    rollover_stage #(.MOD(MIN_MOD), .W(MIN_W)) u_min (
        .clk_i (clk_i), .rst_i (rst_i), .en_i (run_i), .adv_i (c_sec),
        .val_o (min_raw), .carry_o (c_min)
    );

    rollover_stage #(.MOD(HOUR_MOD), .W(HOUR_W)) u_hour (
        .clk_i (clk_i), .rst_i (rst_i), .en_i (run_i), .adv_i (c_min),
        .val_o (hour_raw), .carry_o (c_hour)
    );

    rollover_stage #(.MOD(DAY_MOD), .W(DAY_W)) u_day (
        .clk_i (clk_i), .rst_i (rst_i), .en_i (run_i), .adv_i (c_hour),
        .val_o (day_raw), .carry_o (c_day)
    );

    sat_counter #(.W(YEAR_W)) u_year (
        .clk_i (clk_i), .rst_i (rst_i), .en_i (run_i), .adv_i (c_day),
        .val_o (year_raw)
    );

    align_pipe #(.W(SEC_W), .DEPTH(align_depth(F_SEC))) u_al_sec (
        .clk_i (clk_i), .rst_i (rst_i), .en_i (run_i), .d_i (sec_raw), .q_o (sec_o)
    );

    align_pipe #(.W(MIN_W), .DEPTH(align_depth(F_MIN))) u_al_min (
        .clk_i (clk_i), .rst_i (rst_i), .en_i (run_i), .d_i (min_raw), .q_o (min_o)
    );

    align_pipe #(.W(HOUR_W), .DEPTH(align_depth(F_HOUR))) u_al_hour (
        .clk_i (clk_i), .rst_i (rst_i), .en_i (run_i), .d_i (hour_raw), .q_o (hour_o)
    );

    align_pipe #(.W(DAY_W), .DEPTH(align_depth(F_DAY))) u_al_day (
        .clk_i (clk_i), .rst_i (rst_i), .en_i (run_i), .d_i (day_raw), .q_o (day_o)
    );

    align_pipe #(.W(YEAR_W), .DEPTH(align_depth(F_YEAR))) u_al_year (
        .clk_i (clk_i), .rst_i (rst_i), .en_i (run_i), .d_i (year_raw), .q_o (year_o)
    );

    logic past_ok;
    always_ff @(posedge clk_i) begin
        if (rst_i) past_ok <= 1'b0;
        else       past_ok <= 1'b1;
    end

    // R9: an hour step is only visible together with zeroed seconds and minutes
    a_r9_hour_edge: assert property (@(posedge clk_i) disable iff (rst_i)
        (past_ok && hour_o != $past(hour_o)) |-> (sec_o == '0 && min_o == '0));

    // R4: visible fields frozen while disabled
    a_r4_out_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (past_ok && !run_i) |=> ($stable(sec_o) && $stable(day_o) && $stable(year_o)));

endmodule

// File: tb/watch_core_tb.sv
module watch_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [31:0] div = 32'd3;

    logic [5:0]  sec, min;
    logic [4:0]  hour;
    logic [8:0]  day;
    logic [15:0] year;
    logic        s_sec, s_min, s_hour, s_day;
    logic [1:0]  s_year;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    watch_core u_dut (
        .clk_i (clk), .rst_i (rst), .run_i (run), .div_i (div),
        .sec_o (sec), .min_o (min), .hour_o (hour), .day_o (day), .year_o (year)
    );

    watch_core #(.SEC_MOD(2), .MIN_MOD(2), .HOUR_MOD(2), .DAY_MOD(2), .YEAR_W(2)) u_small (
        .clk_i (clk), .rst_i (rst), .run_i (run), .div_i (div),
        .sec_o (s_sec), .min_o (s_min), .hour_o (s_hour), .day_o (s_day), .year_o (s_year)
    );

    // behavioural reference: period counter, tick latency line, field values
    int mcnt = 0;
    int mlast = 0;
    bit pend [5];
    int mt [2][5];
    int mods [2][5] = '{'{60, 60, 24, 365, 65535}, '{2, 2, 2, 2, 3}};

    function automatic void bump(input int k);
        for (int i = 0; i < 4; i++) begin
            mt[k][i] = mt[k][i] + 1;
            if (mt[k][i] == mods[k][i]) mt[k][i] = 0;
            else return;
        end
        if (mt[k][4] < mods[k][4]) mt[k][4] = mt[k][4] + 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mcnt = 0; mlast = 0;
            for (int i = 0; i < 5; i++) pend[i] = 1'b0;
            for (int k = 0; k < 2; k++)
                for (int i = 0; i < 5; i++) mt[k][i] = 0;
        end else if (run) begin
            int cur;
            bit wrapped;
            bit fire;
            cur = (mcnt == 0) ? ((div <= 1) ? 0 : int'(div) - 1) : mlast;
            if (mcnt == 0) mlast = cur;
            wrapped = (mcnt == cur);
            mcnt = wrapped ? 0 : mcnt + 1;
            fire = pend[4];
            for (int i = 4; i > 0; i--) pend[i] = pend[i-1];
            pend[0] = wrapped;
            if (fire) begin
                bump(0);
                bump(1);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    int prev_hour = 0;
    always @(negedge clk) begin
        cycles++;
        check("R2,R5 seconds", int'(sec), mt[0][0]);
        check("R6 minutes", int'(min), mt[0][1]);
        check("R6 hours", int'(hour), mt[0][2]);
        check("R7 days", int'(day), mt[0][3]);
        check("R8 years", int'(year), mt[0][4]);
        check("R7 small seconds", int'(s_sec), mt[1][0]);
        check("R7 small days", int'(s_day), mt[1][3]);
        check("R8 small years", int'(s_year), mt[1][4]);
        if (int'(hour) != prev_hour) begin
            check("R9 sec zero on hour step", int'(sec), 0);
            check("R9 min zero on hour step", int'(min), 0);
        end
        prev_hour = int'(hour);
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=below 150000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs at zero right after reset
        check("R1 reset sec", int'(sec), 0);
        check("R1 reset year", int'(year), 0);
        rst = 1'b0;
        run = 1'b1;
        // R9: with P=3 seconds reach 1 just after edge 8
        repeat (7) @(posedge clk);
        @(negedge clk);
        check("R9 latency before", int'(sec), 0);
        @(posedge clk);
        @(negedge clk);
        check("R9 latency at edge", int'(sec), 1);
        repeat (200) @(negedge clk);
        // R2: period changed mid-count
        repeat (2) @(negedge clk);
        div = 32'd7;
        repeat (150) @(negedge clk);
        // R4: run toggled with ticks in flight
        for (int n = 0; n < 40; n++) begin
            run = 1'b0;
            repeat (3) @(negedge clk);
            run = 1'b1;
            repeat (5) @(negedge clk);
        end
        // R3: clamped divide values
        div = 32'd0;
        repeat (50) @(negedge clk);
        div = 32'd2;
        repeat (50) @(negedge clk);
        div = 32'd1;
        repeat (87000) @(negedge clk);
        check("R7 day advanced", (int'(day) >= 1) ? 1 : 0, 1);
        check("R8 small year saturated", int'(s_year), 3);
        // R1: reset in the middle of running
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 mid reset hour", int'(hour), 0);
        check("R1 mid reset day", int'(day), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        finish_run();
    end

endmodule